// File: doc/BRIEF.md
# Clock Watchdog with Frequency Recovery

This block supervises the control logic of a clock generator. Software arms it by raising an enable level and writing a configuration byte that holds a timeout count and a prescale choice. A millisecond tick drives a two-stage counter. The first stage groups ticks into timeout steps. The second stage counts those steps down from the programmed value. Software holds off the timeout by rewriting the configuration byte or by pulsing a kick strobe.

If the countdown runs out, a sticky status flag is raised and the frequency selection is overridden. The active divider pair (N, M) then comes from one of two places: a software-programmed recovery pair, or the pair decoded from the hardware straps. A select input chooses between them. While no timeout is pending, the active pair is either the software-programmed pair (when programmed mode is enabled) or the strap pair.

The block can also drive an active-low system reset pulse of fixed length, counted in ticks. One trigger is the timeout, when the timeout trigger is enabled. The other is a frequency-change strobe, when the change trigger is enabled. The PLL, the divider datapaths and the serial register bus lie outside this block.

Top module: `clkwd_top`

## Requirements
- R1: After reset, wd_status=0, rec_active=0, sys_rst_n=1, and act_n/act_m equal strap_n/strap_m while prog_en=0.
- R2: With wd_cfg_wdata bit 0 = 0, wd_cfg_wdata[5:1]=T (T>0) and wd_en=1, wd_status rises exactly T*STEP_TICKS ticks after the write is sampled.
- R3: With wd_cfg_wdata bit 0 = 1, each timeout step lasts ALT_MULT*STEP_TICKS ticks (ALT_MULT=4), so the timeout is T*4*STEP_TICKS ticks.
- R4: A configuration write or a wd_kick pulse restarts the full timeout. A kick sampled in the very cycle that would expire wins, and no timeout is recorded.
- R5: A timeout value of zero never produces a timeout.
- R6: wd_status stays 1 while wd_en=1. wd_en=0 clears it one cycle later, and no counting happens while wd_en=0, so re-enabling restarts the full timeout.
- R7: While wd_status=1, rec_active=1 and act_n/act_m equal rec_n/rec_m when rec_use_sw=1, or strap_n/strap_m when rec_use_sw=0, regardless of prog_en.
- R8: While wd_status=0, act_n/act_m equal prog_n/prog_m when prog_en=1, and strap_n/strap_m when prog_en=0.
- R9: With rst_on_wd=1, a timeout drives sys_rst_n low for exactly RST_TICKS=4 ticks, starting the cycle after expiry. With rst_on_wd=0, a timeout gives no pulse.
- R10: With rst_on_fchg=1, a one-cycle fchg_strobe drives sys_rst_n low for exactly 4 ticks, starting the next cycle. With rst_on_fchg=0, the strobe has no effect on sys_rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per base time unit |
| wd_cfg_wr | input | 1 | Configuration write strobe (also reloads) |
| wd_cfg_wdata | input | TO_W+1 | Bits TO_W:1 timeout count, bit 0 long-step select |
| wd_kick | input | 1 | Service strobe, reloads the countdown |
| wd_en | input | 1 | Watchdog enable level; low clears status |
| rst_on_wd | input | 1 | Enable reset pulse on timeout |
| rst_on_fchg | input | 1 | Enable reset pulse on frequency change |
| fchg_strobe | input | 1 | Output frequency setting changed |
| rec_use_sw | input | 1 | Recovery source: 1 software pair, 0 strap pair |
| strap_n | input | N_W | Strap-decoded N value |
| strap_m | input | M_W | Strap-decoded M value |
| rec_n | input | N_W | Software recovery N value |
| rec_m | input | M_W | Software recovery M value |
| prog_en | input | 1 | Programmed frequency mode enable |
| prog_n | input | N_W | Programmed N value |
| prog_m | input | M_W | Programmed M value |
| rec_active | output | 1 | Recovery selection in force |
| act_n | output | N_W | Active N value |
| act_m | output | M_W | Active M value |
| wd_status | output | 1 | Sticky timeout flag |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
Two events can land on the same edge: the service reload and the expiry. To provoke this, the bench raises wd_kick so that it is sampled on the exact edge where the countdown would reach zero. It then judges that wd_status stays low on that edge and that a complete new timeout follows. The reset generator is exercised from both triggers. Each time, the bench counts the low cycles of sys_rst_n against the fixed tick length.

// File: rtl/clkwd_pkg.sv
package clkwd_pkg;
  typedef enum logic [1:0] {
    FSRC_STRAP,
    FSRC_PROG,
    FSRC_REC_STRAP,
    FSRC_REC_SW
  } fsrc_e;
endpackage

// File: rtl/clkwd_prescale.sv
module clkwd_prescale #(
  parameter int STEP_TICKS = 150,
  parameter int ALT_MULT   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  input  logic run,
  input  logic alt,
  output logic step
);
  localparam int MAX_LIM = STEP_TICKS * ALT_MULT;
  localparam int CW      = $clog2(MAX_LIM + 1);
  localparam logic [CW-1:0] TERM_BASE = CW'(STEP_TICKS - 1);
  localparam logic [CW-1:0] TERM_ALT  = CW'(MAX_LIM - 1);

  logic [CW-1:0] cnt_q, cnt_d, term;
  logic          cnt_ce;

  generate
    if (ALT_MULT > 1) begin : g_two_scales
      assign term = alt ? TERM_ALT : TERM_BASE;
    end else begin : g_one_scale
      assign term = TERM_BASE;
    end
  endgenerate

  assign step   = run && tick && (cnt_q >= term);
  assign cnt_ce = clear || (run && tick);

  always_comb begin
    if (clear)     cnt_d = '0;
    else if (step) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R2/R3: after a step the grouping counter starts over
  a_r2_step_restarts_group: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == '0));
  // R6: nothing advances while stopped and not cleared
  a_r6_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/clkwd_timer.sv
module clkwd_timer #(
  parameter int TO_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            reload,
  input  logic            step,
  input  logic [TO_W-1:0] tmo,
  output logic            armed,
  output logic            expire,
  output logic            status
);
  logic [TO_W-1:0] cnt_q, cnt_d;
  logic            cnt_ce;
  logic            status_q, status_d;

  assign armed  = en && (tmo != '0) && !status_q;
  assign expire = armed && step && !reload && (cnt_q == TO_W'(1));
  assign status = status_q;
  assign cnt_ce = reload || !en || (armed && step);

  always_comb begin
    if (reload || !en) cnt_d = tmo;
    else               cnt_d = cnt_q - TO_W'(1);
  end

  always_comb begin
    if (!en)         status_d = 1'b0;
    else if (expire) status_d = 1'b1;
    else             status_d = status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= status_d;
  end

  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && en) |=> status_q);
  a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !status_q);
  a_r5_zero_never_expires: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo == '0) |-> !expire);
  a_r4_reload_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == $past(tmo)));
endmodule

// File: rtl/clkwd_rstgen.sv
module clkwd_rstgen #(
  parameter int PULSE_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic trig,
  output logic rst_out_n
);
  localparam int PW = $clog2(PULSE_TICKS + 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;

  assign cnt_ce    = trig || (tick && (cnt_q != '0));
  assign rst_out_n = (cnt_q == '0);

  always_comb begin
    if (trig) cnt_d = PW'(PULSE_TICKS);
    else      cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  a_r9_pulse_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> $past(trig));
  a_r10_pulse_waits_for_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out_n && !tick && !trig) |=> !rst_out_n);
endmodule

// File: rtl/clkwd_recsel.sv
module clkwd_recsel
  import clkwd_pkg::*;
#(
  parameter int N_W = 8,
  parameter int M_W = 7
) (
  input  logic           timed_out,
  input  logic           rec_use_sw,
  input  logic           prog_en,
  input  logic [N_W-1:0] strap_n,
  input  logic [M_W-1:0] strap_m,
  input  logic [N_W-1:0] rec_n,
  input  logic [M_W-1:0] rec_m,
  input  logic [N_W-1:0] prog_n,
  input  logic [M_W-1:0] prog_m,
  output logic [N_W-1:0] act_n,
  output logic [M_W-1:0] act_m
);
  fsrc_e src;

  always_comb begin
    if (timed_out) src = rec_use_sw ? FSRC_REC_SW : FSRC_REC_STRAP;
    else           src = prog_en ? FSRC_PROG : FSRC_STRAP;
  end

  always_comb begin
    unique case (src)
      FSRC_PROG:   begin act_n = prog_n; act_m = prog_m; end
      FSRC_REC_SW: begin act_n = rec_n;  act_m = rec_m;  end
      default:     begin act_n = strap_n; act_m = strap_m; end
    endcase
  end
endmodule

// File: rtl/clkwd_top.sv
module clkwd_top #(
  parameter int STEP_TICKS = 150,
  parameter int ALT_MULT   = 4,
  parameter int TO_W       = 5,
  parameter int RST_TICKS  = 4,
  parameter int N_W        = 8,
  parameter int M_W        = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ms_tick,
  input  logic           wd_cfg_wr,
  input  logic [TO_W:0]  wd_cfg_wdata,
  input  logic           wd_kick,
  input  logic           wd_en,
  input  logic           rst_on_wd,
  input  logic           rst_on_fchg,
  input  logic           fchg_strobe,
  input  logic           rec_use_sw,
  input  logic [N_W-1:0] strap_n,
  input  logic [M_W-1:0] strap_m,
  input  logic [N_W-1:0] rec_n,
  input  logic [M_W-1:0] rec_m,
  input  logic           prog_en,
  input  logic [N_W-1:0] prog_n,
  input  logic [M_W-1:0] prog_m,
  output logic           rec_active,
  output logic [N_W-1:0] act_n,
  output logic [M_W-1:0] act_m,
  output logic           wd_status,
  output logic           sys_rst_n
);
  logic [TO_W-1:0] tmo_q, tmo_d;
  logic            alt_q, alt_d;
  logic            reload, armed, step, expire, rst_trig;

  assign tmo_d    = wd_cfg_wr ? wd_cfg_wdata[TO_W:1] : tmo_q;
  assign alt_d    = wd_cfg_wr ? wd_cfg_wdata[0] : alt_q;
  assign reload   = wd_cfg_wr || wd_kick;
  assign rst_trig = (expire && rst_on_wd) || (fchg_strobe && rst_on_fchg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q <= '0;
      alt_q <= 1'b0;
    end else if (wd_cfg_wr) begin
      tmo_q <= tmo_d;
      alt_q <= alt_d;
    end
  end

  clkwd_prescale #(.STEP_TICKS(STEP_TICKS), .ALT_MULT(ALT_MULT)) u_prescale (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .clear(reload || !armed),
    .run(armed), .alt(alt_d), .step(step));

  clkwd_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(wd_en), .reload(reload), .step(step),
    .tmo(tmo_d), .armed(armed), .expire(expire), .status(wd_status));

  clkwd_rstgen #(.PULSE_TICKS(RST_TICKS)) u_rstgen (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .trig(rst_trig),
    .rst_out_n(sys_rst_n));

  clkwd_recsel #(.N_W(N_W), .M_W(M_W)) u_recsel (
    .timed_out(wd_status), .rec_use_sw(rec_use_sw), .prog_en(prog_en),
    .strap_n(strap_n), .strap_m(strap_m), .rec_n(rec_n), .rec_m(rec_m),
    .prog_n(prog_n), .prog_m(prog_m), .act_n(act_n), .act_m(act_m));

  assign rec_active = wd_status;

  a_r7_sw_recovery_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_status && rec_use_sw) |-> (act_n == rec_n && act_m == rec_m));
  a_r8_prog_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_status && prog_en) |-> (act_n == prog_n && act_m == prog_m));
  a_r9_timeout_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && rst_on_wd) |=> !sys_rst_n);
  a_r10_fchg_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (fchg_strobe && rst_on_fchg) |=> !sys_rst_n);
endmodule

// File: tb/clkwd_top_bench.sv
module clkwd_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 2;
  localparam int NV = 5;
  localparam int V_T   [NV] = '{1, 2, 5, 31, 3};
  localparam int V_ALT [NV] = '{0, 0, 1, 0, 1};
  localparam int V_EXP [NV] = '{2, 4, 40, 62, 24};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ms_tick = 1'b1, wd_cfg_wr = 1'b0, wd_kick = 1'b0, wd_en = 1'b0;
  logic [5:0] wd_cfg_wdata = '0;
  logic rst_on_wd = 1'b0, rst_on_fchg = 1'b0, fchg_strobe = 1'b0;
  logic rec_use_sw = 1'b0, prog_en = 1'b0;
  logic [7:0] strap_n = 8'h21, rec_n = 8'h5C, prog_n = 8'h77;
  logic [6:0] strap_m = 7'h0A, rec_m = 7'h33, prog_m = 7'h19;
  logic rec_active, wd_status, sys_rst_n;
  logic [7:0] act_n;
  logic [6:0] act_m;
  int nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkwd_top #(.STEP_TICKS(STEP)) u_clkwd_top (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wd_cfg_wr(wd_cfg_wr),
    .wd_cfg_wdata(wd_cfg_wdata), .wd_kick(wd_kick), .wd_en(wd_en),
    .rst_on_wd(rst_on_wd), .rst_on_fchg(rst_on_fchg), .fchg_strobe(fchg_strobe),
    .rec_use_sw(rec_use_sw), .strap_n(strap_n), .strap_m(strap_m),
    .rec_n(rec_n), .rec_m(rec_m), .prog_en(prog_en), .prog_n(prog_n),
    .prog_m(prog_m), .rec_active(rec_active), .act_n(act_n), .act_m(act_m),
    .wd_status(wd_status), .sys_rst_n(sys_rst_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int t, input int alt);
    @(negedge clk);
    wd_cfg_wr = 1'b1;
    wd_cfg_wdata = {t[4:0], alt[0]};
    @(posedge clk);
    @(negedge clk);
    wd_cfg_wr = 1'b0;
  endtask

  task automatic clear_status();
    @(negedge clk); wd_en = 1'b0;
    @(negedge clk); wd_en = 1'b1;
  endtask

  task automatic count_status(input int maxc, output int n);
    n = 0;
    while (n < maxc) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (wd_status) break;
    end
  endtask

  task automatic count_low(input int cyc, output int low);
    low = 0;
    for (int i = 0; i < cyc; i++) begin
      if (!sys_rst_n) low++;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int n, low;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(wd_status == 0 && rec_active == 0, "R1 status", wd_status, 0);
    check(sys_rst_n == 1, "R1 sys_rst_n", sys_rst_n, 1);
    check(act_n == strap_n && act_m == strap_m, "R1 act_n", act_n, strap_n);
    // R8 programmed pair
    prog_en = 1'b1; #1;
    check(act_n == prog_n && act_m == prog_m, "R8 prog", act_n, prog_n);
    prog_en = 1'b0; #1;
    check(act_n == strap_n, "R8 strap", act_n, strap_n);

    // R2 / R3 timeout length table
    wd_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      cfg_write(V_T[i], V_ALT[i]);
      count_status(200, n);
      check(n == V_EXP[i], V_ALT[i] ? "R3 long step timeout" : "R2 base timeout", n, V_EXP[i]);
      clear_status();
    end

    // R4 kick mid-count restarts
    cfg_write(3, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); wd_kick = 1'b1;
    @(posedge clk);
    @(negedge clk); wd_kick = 1'b0;
    count_status(200, n);
    check(n == 6, "R4 kick restart", n, 6);
    clear_status();
    // R4 kick on the expiry edge
    cfg_write(2, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); wd_kick = 1'b1;
    @(posedge clk);
    @(negedge clk); wd_kick = 1'b0;
    check(wd_status == 0, "R4 kick beats expiry", wd_status, 0);
    count_status(200, n);
    check(n == 4, "R4 full timeout after kick", n, 4);
    clear_status();

    // R5 zero timeout
    cfg_write(0, 0);
    count_status(300, n);
    check(wd_status == 0 && n == 300, "R5 zero never expires", wd_status, 0);

    // R6 sticky status, disable clears, no counting while disabled
    cfg_write(2, 0);
    count_status(200, n);
    repeat (10) @(negedge clk);
    check(wd_status == 1, "R6 sticky", wd_status, 1);
    wd_en = 1'b0;
    @(negedge clk);
    check(wd_status == 0, "R6 disable clears", wd_status, 1'b0);
    repeat (20) @(negedge clk);
    check(wd_status == 0, "R6 idle while disabled", wd_status, 0);
    wd_en = 1'b1;
    count_status(200, n);
    check(n == 4, "R6 full timeout after enable", n, 4);

    // R7 recovery selection (status is 1 here)
    prog_en = 1'b1; rec_use_sw = 1'b1; #1;
    check(rec_active == 1, "R7 rec_active", rec_active, 1);
    check(act_n == rec_n && act_m == rec_m, "R7 sw pair", act_n, rec_n);
    rec_use_sw = 1'b0; #1;
    check(act_n == strap_n && act_m == strap_m, "R7 strap pair", act_n, strap_n);
    clear_status(); #1;
    check(rec_active == 0 && act_n == prog_n, "R8 after clear", act_n, prog_n);
    prog_en = 1'b0;

    // R9 reset pulse on timeout
    rst_on_wd = 1'b1;
    clear_status();
    cfg_write(1, 0);
    count_low(12, low);
    check(low == 4, "R9 pulse length", low, 4);
    rst_on_wd = 1'b0;
    clear_status();
    cfg_write(1, 0);
    count_low(12, low);
    check(low == 0, "R9 no pulse when disabled", low, 0);
    check(wd_status == 1, "R9 timeout occurred", wd_status, 1);

    // R10 reset pulse on frequency change
    rst_on_fchg = 1'b1;
    @(negedge clk); fchg_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk); fchg_strobe = 1'b0;
    count_low(10, low);
    check(low == 4, "R10 pulse length", low, 4);
    rst_on_fchg = 1'b0;
    @(negedge clk); fchg_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk); fchg_strobe = 1'b0;
    count_low(10, low);
    check(low == 0, "R10 strobe ignored", low, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule